// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block gathers level-sensitive interrupt lines into groups of 32 and presents each group to a host as a small register window. Each window holds a read-only view of the captured request lines and three independent enable masks. The first mask routes requests to the normal interrupt output. The second routes them to the fast interrupt output. The third drives a per-group endpoint output, one bit for each group.

Request lines are sampled every clock. A captured bit stays set for exactly as long as its line is held high, so the block never latches an edge. A host clears a request at the device that raised it, not in this controller.

The block also finds the lowest-numbered request that is both pending and enabled for the normal output, and reports its global index with a valid flag. Software can use that index to pick a handler without scanning the banks. The host interface is a plain 32-bit word bus with a combinational read path.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Global source n appears at bit n mod 32 of the cause register of bank n div 32. Bank b's window starts at byte address 16*b, with the cause register at offset 0x0.
- R2: A cause bit equals the level its source line had at the previous rising clock edge, so a bit falls one cycle after its line is released.
- R3: Writes to a cause register (offset 0x0) change no register in the block.
- R4: After reset every mask register reads zero, and irq_o, fiq_o, ep_o and pend_valid_o stay low whatever the source lines do.
- R5: Offsets 0x4, 0x8 and 0xC of a bank window hold the normal mask, the fast mask and the endpoint mask. All 32 bits are writable and read back as written. Address bits [1:0] are ignored.
- R6: irq_o is high when any bank has a cause bit whose normal mask bit is 1. irq_o changes one clock edge after the source line changes.
- R7: fiq_o is high when any bank has a cause bit whose fast mask bit is 1, independently of the normal mask.
- R8: ep_o[b] is high when bank b has a cause bit whose endpoint mask bit is 1.
- R9: pend_valid_o equals irq_o. When it is high, pend_idx_o is the lowest global index whose cause bit and normal mask bit are both 1.
- R10: Addresses whose bank field (bits above bit 3) is at or beyond the bank count read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_BANKS*32 | Level-sensitive request lines |
| bus_wr_i | input | 1 | Write strobe, takes effect at the rising edge |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| ep_o | output | NUM_BANKS | Per-bank endpoint-masked request |
| pend_valid_o | output | 1 | An enabled normal request is pending |
| pend_idx_o | output | clog2(NUM_BANKS*32) | Lowest pending enabled global index |

## Verification
The bench uses the default build of two banks (64 sources) and an 8-bit address. This makes every source index reachable in a single walking-one sweep, with an exact expected index, cause word and endpoint bit for each of the 64 positions. The 8-bit address leaves fourteen unmapped windows, and the bench reads every word in them and writes into them. Pseudo-random source patterns against uneven masks in both banks exercise the lowest-index search across the bank boundary.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int BANK_W  = 32;
  localparam int WIN_LSB = 4;

  typedef enum logic [1:0] {
    REG_CAUSE = 2'd0,
    REG_NORM  = 2'd1,
    REG_FAST  = 2'd2,
    REG_ENDP  = 2'd3
  } reg_sel_e;

  function automatic logic any_gated(input logic [BANK_W-1:0] req,
                                     input logic [BANK_W-1:0] en);
    return |(req & en);
  endfunction
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  localparam int BANK_IDX_W = ADDR_W - WIN_LSB
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [BANK_IDX_W-1:0] bank_idx_o,
  output reg_sel_e              reg_sel_o,
  output logic                  hit_o
);
  localparam logic [BANK_IDX_W:0] NB = NUM_BANKS[BANK_IDX_W:0];

  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];

  assign bank_idx_o = addr_i[ADDR_W-1:WIN_LSB];
  assign reg_sel_o  = reg_sel_e'(addr_i[3:2]);
  assign hit_o      = ({1'b0, bank_idx_o} < NB);
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] src_i,
  input  logic              wr_i,
  input  reg_sel_e          reg_sel_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] cause_o,
  output logic [BANK_W-1:0] normm_o,
  output logic [BANK_W-1:0] fastm_o,
  output logic [BANK_W-1:0] endpm_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_o <= '0;
      normm_o <= '0;
      fastm_o <= '0;
      endpm_o <= '0;
    end else begin
      cause_o <= src_i;
      if (wr_i) begin
        case (reg_sel_i)
          REG_NORM: normm_o <= wdata_i;
          REG_FAST: fastm_o <= wdata_i;
          REG_ENDP: endpm_o <= wdata_i;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     vec_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  function automatic logic [IDX_W-1:0] first_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign valid_o = |vec_i;
  assign idx_o   = first_set(vec_i);
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  localparam int NUM_SRC  = NUM_BANKS * BANK_W,
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_i,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic                 irq_o,
  output logic                 fiq_o,
  output logic [NUM_BANKS-1:0] ep_o,
  output logic                 pend_valid_o,
  output logic [IDX_W-1:0]     pend_idx_o
);
  localparam int BANK_IDX_W = ADDR_W - WIN_LSB;

  logic [BANK_IDX_W-1:0] bank_idx;
  reg_sel_e              reg_sel;
  logic                  addr_hit;

  logic [BANK_W-1:0] cause_b [NUM_BANKS];
  logic [BANK_W-1:0] normm_b [NUM_BANKS];
  logic [BANK_W-1:0] fastm_b [NUM_BANKS];
  logic [BANK_W-1:0] endpm_b [NUM_BANKS];

  logic [NUM_SRC-1:0]   cause_flat, normm_flat, fastm_flat, endpm_flat;
  logic [NUM_SRC-1:0]   irq_hit_flat;
  logic [NUM_BANKS-1:0] norm_any, fast_any;
  logic                 cause_wr_hit;

  irqc_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i     (bus_addr_i),
    .bank_idx_o (bank_idx),
    .reg_sel_o  (reg_sel),
    .hit_o      (addr_hit)
  );

  assign cause_wr_hit = bus_wr_i && addr_hit && (reg_sel == REG_CAUSE);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic wr_g;
    assign wr_g = bus_wr_i && addr_hit && (bank_idx == BANK_IDX_W'(g));

    irqc_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_i     (src_i[g*BANK_W +: BANK_W]),
      .wr_i      (wr_g),
      .reg_sel_i (reg_sel),
      .wdata_i   (bus_wdata_i),
      .cause_o   (cause_b[g]),
      .normm_o   (normm_b[g]),
      .fastm_o   (fastm_b[g]),
      .endpm_o   (endpm_b[g])
    );

    assign cause_flat[g*BANK_W +: BANK_W] = cause_b[g];
    assign normm_flat[g*BANK_W +: BANK_W] = normm_b[g];
    assign fastm_flat[g*BANK_W +: BANK_W] = fastm_b[g];
    assign endpm_flat[g*BANK_W +: BANK_W] = endpm_b[g];

    assign norm_any[g] = any_gated(cause_b[g], normm_b[g]);
    assign fast_any[g] = any_gated(cause_b[g], fastm_b[g]);
    assign ep_o[g]     = any_gated(cause_b[g], endpm_b[g]);
  end

  assign irq_hit_flat = cause_flat & normm_flat;
  assign irq_o        = |norm_any;
  assign fiq_o        = |fast_any;

  irqc_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
    .vec_i   (irq_hit_flat),
    .valid_o (pend_valid_o),
    .idx_o   (pend_idx_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (addr_hit && bank_idx == BANK_IDX_W'(b)) begin
        case (reg_sel)
          REG_CAUSE: bus_rdata_o = cause_b[b];
          REG_NORM:  bus_rdata_o = normm_b[b];
          REG_FAST:  bus_rdata_o = fastm_b[b];
          REG_ENDP:  bus_rdata_o = endpm_b[b];
          default:   bus_rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_BANKS = 2,
  parameter int NUM_SRC   = 64,
  parameter int IDX_W     = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SRC-1:0]   src_i,
  input logic                 irq_o,
  input logic                 fiq_o,
  input logic [NUM_BANKS-1:0] ep_o,
  input logic                 pend_valid_o,
  input logic [IDX_W-1:0]     pend_idx_o,
  input logic [31:0]          bus_rdata_o,
  input logic [NUM_SRC-1:0]   cause_flat,
  input logic [NUM_SRC-1:0]   normm_flat,
  input logic [NUM_SRC-1:0]   fastm_flat,
  input logic [NUM_SRC-1:0]   endpm_flat,
  input logic [NUM_SRC-1:0]   irq_hit_flat,
  input logic                 addr_hit,
  input logic                 cause_wr_hit
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  logic [NUM_SRC-1:0] below;
  assign below = (NUM_SRC'(1) << pend_idx_o) - NUM_SRC'(1);

  // R2: captured lines equal the lines seen one edge earlier
  assert_cause_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cause_flat == $past(src_i)));

  // R3: a write aimed at a cause register leaves every mask untouched
  assert_cause_wr_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr_hit |=> ($stable(normm_flat) && $stable(fastm_flat) && $stable(endpm_flat)));

  // R4: outputs quiet on the first cycle out of reset
  assert_quiet_after_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_o && !fiq_o && ep_o == '0 && !pend_valid_o));

  // R9: the search unit and the OR tree agree
  assert_pend_matches_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o == irq_o);

  // R9: reported index is pending and nothing lower is
  assert_pend_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o |-> (irq_hit_flat[pend_idx_o] && (irq_hit_flat & below) == '0));

  // R10: unmapped addresses read as zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> (bus_rdata_o == 32'h0));
endmodule

bind banked_irq_ctrl irqc_checker #(
  .NUM_BANKS (NUM_BANKS),
  .NUM_SRC   (NUM_SRC),
  .IDX_W     (IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_i        (src_i),
  .irq_o        (irq_o),
  .fiq_o        (fiq_o),
  .ep_o         (ep_o),
  .pend_valid_o (pend_valid_o),
  .pend_idx_o   (pend_idx_o),
  .bus_rdata_o  (bus_rdata_o),
  .cause_flat   (cause_flat),
  .normm_flat   (normm_flat),
  .fastm_flat   (fastm_flat),
  .endpm_flat   (endpm_flat),
  .irq_hit_flat (irq_hit_flat),
  .addr_hit     (addr_hit),
  .cause_wr_hit (cause_wr_hit)
);

// File: tb/tb_banked_irq_ctrl.sv
`timescale 1ns/1ps
module tb_banked_irq_ctrl;
  localparam int NB = 2;
  localparam int NS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq, pv;
  logic [1:0]  ep;
  logic [5:0]  pidx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq),
    .ep_o(ep), .pend_valid_o(pv), .pend_idx_o(pidx)
  );

  logic [63:0] m_norm, m_fast, m_endp;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic set_src(input logic [63:0] s);
    @(negedge clk);
    src = s;
    @(negedge clk);
    #1;
  endtask

  task automatic load_masks;
    bus_write(8'h04, m_norm[31:0]);  bus_write(8'h14, m_norm[63:32]);
    bus_write(8'h08, m_fast[31:0]);  bus_write(8'h18, m_fast[63:32]);
    bus_write(8'h0C, m_endp[31:0]);  bus_write(8'h1C, m_endp[63:32]);
  endtask

  task automatic check_outputs(input string req);
    logic [63:0] h;
    int lo;
    h = src & m_norm;
    lo = 0;
    for (int i = NS - 1; i >= 0; i--) if (h[i]) lo = i;
    check(irq == (h != 0), {req, " irq"}, 64'(irq), 64'(h != 0));
    check(fiq == ((src & m_fast) != 0), {req, " fiq"}, 64'(fiq), 64'((src & m_fast) != 0));
    check(ep == {|(src[63:32] & m_endp[63:32]), |(src[31:0] & m_endp[31:0])},
          {req, " ep"}, 64'(ep),
          64'({|(src[63:32] & m_endp[63:32]), |(src[31:0] & m_endp[31:0])}));
    if (h != 0) check(pidx == 6'(lo), {req, " idx"}, 64'(pidx), 64'(lo));
  endtask

  initial begin
    logic [31:0] d;
    logic [63:0] lfsr;

    src = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R4: masks zero so nothing propagates
    check(!irq && !fiq && ep == 2'b00 && !pv, "R4 outputs", {irq, fiq, ep, pv}, 0);
    for (int b = 0; b < NB; b++)
      for (int r = 1; r < 4; r++) begin
        bus_read(8'(b * 16 + r * 4), d);
        check(d == 0, "R4 mask reset", 64'(d), 0);
      end
    bus_read(8'h00, d);
    check(d == 32'hFFFF_FFFF, "R2 cause level", 64'(d), 64'hFFFF_FFFF);

    // R5: mask read/write, low address bits ignored
    bus_write(8'h04, 32'hA5A5_0F0F);
    bus_write(8'h1B, 32'h1234_5678);
    bus_write(8'h1D, 32'hDEAD_BEEF);
    bus_read(8'h04, d); check(d == 32'hA5A5_0F0F, "R5 norm b0", 64'(d), 64'hA5A5_0F0F);
    bus_read(8'h18, d); check(d == 32'h1234_5678, "R5 fast b1", 64'(d), 64'h1234_5678);
    bus_read(8'h1C, d); check(d == 32'hDEAD_BEEF, "R5 endp b1", 64'(d), 64'hDEAD_BEEF);
    bus_read(8'h14, d); check(d == 0, "R5 norm b1 untouched", 64'(d), 0);

    // R3: writes to cause do nothing
    bus_write(8'h00, 32'h0);
    bus_write(8'h10, 32'h0);
    bus_read(8'h00, d); check(d == 32'hFFFF_FFFF, "R3 cause b0", 64'(d), 64'hFFFF_FFFF);
    bus_read(8'h04, d); check(d == 32'hA5A5_0F0F, "R3 norm b0 kept", 64'(d), 64'hA5A5_0F0F);
    bus_read(8'h18, d); check(d == 32'h1234_5678, "R3 fast b1 kept", 64'(d), 64'h1234_5678);

    // R10: unmapped windows
    for (int a = 32; a < 256; a += 4) begin
      bus_write(8'(a), 32'hFFFF_FFFF);
      bus_read(8'(a), d);
      check(d == 0, "R10 unmapped read", 64'(d), 0);
    end
    bus_read(8'h14, d); check(d == 0, "R10 no aliasing", 64'(d), 0);
    bus_read(8'h08, d); check(d == 0, "R10 no aliasing", 64'(d), 0);

    // walking one: R1 R6 R8 R9
    m_norm = '1; m_fast = '0; m_endp = {32'h0, 32'hFFFF_FFFF};
    load_masks();
    set_src('0);
    check(!irq && !pv, "R6 idle", {irq, pv}, 0);
    @(negedge clk);
    src = 64'h1 << 45;
    #1;
    check(!irq, "R6 one-edge latency", 64'(irq), 0);
    @(negedge clk); #1;
    check(irq && pidx == 6'd45, "R6 after edge", {irq, pidx}, {1'b1, 6'd45});
    for (int n = 0; n < NS; n++) begin
      set_src(64'h1 << n);
      check_outputs("R1 R6 R8 R9 walk");
      bus_read(8'((n / 32) * 16), d);
      check(d == 32'h1 << (n % 32), "R1 cause bit", 64'(d), 64'h1 << (n % 32));
      bus_read(8'(((n / 32) ^ 1) * 16), d);
      check(d == 0, "R1 other bank", 64'(d), 0);
    end

    // R7: fast path independent of normal mask
    m_norm = '0; m_fast = 64'h1 << 37; m_endp = '0;
    load_masks();
    set_src(64'h1 << 37);
    check(fiq && !irq && !pv, "R7 fast only", {fiq, irq, pv}, 3'b100);
    set_src(64'h1 << 36);
    check(!fiq, "R7 unmasked", 64'(fiq), 0);

    // R9 R8 R7 patterns
    m_norm = {32'hFFFF_FFFF, 32'hF0F0_F0F0};
    m_fast = {32'h0000_FFFF, 32'h8000_0001};
    m_endp = {32'h0101_0101, 32'h00FF_0000};
    load_masks();
    lfsr = 64'hACE1_2468_1357_BDF9;
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      set_src(k[0] ? (lfsr & {32'hFFFF_FFFF, 32'h0}) : (lfsr & (lfsr >> 7)));
      check_outputs("R9 R8 R7 pattern");
    end

    // R2: release of all lines clears the next cycle
    set_src('0);
    bus_read(8'h10, d);
    check(d == 0, "R2 release", 64'(d), 0);
    check(!irq && !fiq && ep == 0, "R2 outputs drop", {irq, fiq, ep}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule